// File: doc/BRIEF.md
# Countdown Issue Queue with Switchback Replay

This block sits between an instruction pre-scheduler and the functional units. Each instruction arrives with a predicted wait, measured in cycles until it should issue. It is written into the countdown pipeline at the stage whose index equals that wait. On every cycle all stages move one step toward stage 0, which is the issue point. No wakeup broadcast and no tag comparison take place. When an instruction reaches stage 0, the block reads the ready bits of its two source registers.

If both ready bits are set, the instruction issues, and its destination ready bit is scheduled to rise after the instruction's latency. If either bit is clear, the instruction is replayed instead. The switchback path writes it back into the pipeline at a fixed rejoin stage, and it travels toward the issue point again. Readiness passes between instructions only through the per-register ready bits. A dispatch clears the ready bit of its destination, and an issue sets that bit again after a delay.

A replayed instruction and an instruction moving down from the stage above can both need the rejoin stage in the same cycle. In that case the replayed instruction wins, and the queued instruction, together with every stage above it, holds in place for that cycle. A new instruction is accepted only when its target stage will be free in the next cycle.

Top module: `countdown_issue_queue`

## Requirements
- R1: After reset the pipeline is empty: `iss_valid` and `rep_valid` are low, all `reg_ready` bits are 1, and `in_ready` is high for any wait value below DEPTH (8).
- R2: An accepted instruction with wait w and ready sources appears at the issue point exactly w+1 cycles after the cycle in which it was accepted. It issues there with its own `iss_id` and `iss_dst`.
- R3: At the issue point, the instruction issues only if the ready bits of both its sources are 1. Otherwise `iss_valid` stays low and `rep_valid` rises with the instruction's id in `rep_id`.
- R4: A replayed instruction rejoins the pipeline at stage SWB_STAGE (3). It is evaluated again at the issue point SWB_STAGE+1 (4) cycles after the cycle in which it was replayed.
- R5: If a replay happens while stage SWB_STAGE+1 is occupied, that entry and all stages above it keep their contents for one cycle. Each of those instructions therefore reaches the issue point one cycle later.
- R6: `in_ready` is low when the target stage will be occupied in the next cycle, whether by a shifting entry or by a replayed instruction. A replayed instruction takes priority over a new instruction targeting the same stage. A refused instruction has no effect: it never issues and its destination ready bit does not change.
- R7: An accepted instruction clears its destination's ready bit, and the clear is visible in the next cycle.
- R8: An instruction issued with latency L (values 1 to MAX_LAT, where 0 counts as 1) sets its destination ready bit so that the bit is visible L cycles after the issue cycle. With L=1, a dependent instruction can issue in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New pre-scheduled instruction present |
| in_ready | output | 1 | Target stage is free, so the instruction is accepted this cycle |
| in_wait | input | CNT_W (3) | Predicted cycles until issue, which is also the target stage |
| in_id | input | ID_W (4) | Instruction identifier |
| in_src0 | input | REG_W (4) | First source register |
| in_src1 | input | REG_W (4) | Second source register |
| in_dst | input | REG_W (4) | Destination register |
| in_lat | input | LAT_W (3) | Execution latency in cycles |
| iss_valid | output | 1 | Instruction at the issue point goes to execution |
| iss_id | output | ID_W (4) | Id of the issuing instruction |
| iss_dst | output | REG_W (4) | Destination of the issuing instruction |
| rep_valid | output | 1 | Instruction at the issue point is replayed over the switchback path |
| rep_id | output | ID_W (4) | Id of the replayed instruction |
| reg_ready | output | NREG (16) | Per-register ready bits |

## Verification
Two functions can fall in the same cycle: a replay writing the rejoin stage, and either the shift of an occupied stage above it or a new insertion aimed at that stage. The bench sets this up by parking an instruction so that it sits at stage SWB_STAGE+1 when a dependent instruction whose producer is still unready reaches the issue point. In that same cycle it also presents a new instruction with wait SWB_STAGE. The outcome is judged by three observations: the new instruction is refused and leaves no trace, the replayed instruction issues exactly four cycles later, and the parked instruction issues one cycle after it rather than on its original schedule.

// File: rtl/ciq_pkg.sv
package ciq_pkg;

   localparam int unsigned CIQ_DEF_DEPTH   = 8;
   localparam int unsigned CIQ_DEF_NREG    = 16;
   localparam int unsigned CIQ_DEF_MAX_LAT = 4;

   // Width of one packed queue entry: {id, src0, src1, dst, lat}
   function automatic int unsigned ciq_ent_w(input int unsigned id_w,
                                             input int unsigned reg_w,
                                             input int unsigned lat_w);
      return id_w + 3 * reg_w + lat_w;
   endfunction

endpackage

// File: rtl/ciq_pipe.sv
module ciq_pipe #(
   parameter int DEPTH     = 8,
   parameter int SWB_STAGE = 3,
   parameter int ENT_W     = 19,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_valid,
   input  logic [CNT_W-1:0] ins_wait,
   input  logic [ENT_W-1:0] ins_ent,
   output logic             ins_ready,
   input  logic             rep_en,
   output logic             head_valid,
   output logic [ENT_W-1:0] head_ent,
   output logic             st_vld [DEPTH],
   output logic [ENT_W-1:0] st_ent [DEPTH]
);

   logic             vld    [DEPTH];
   logic [ENT_W-1:0] ent    [DEPTH];
   logic             base_v [DEPTH];
   logic [ENT_W-1:0] base_e [DEPTH];
   logic             nxt_v  [DEPTH];
   logic [ENT_W-1:0] nxt_e  [DEPTH];
   logic             hold;
   logic             accept;

   // Stages above the rejoin point stall when the replay takes their slot
   generate
      if (SWB_STAGE < DEPTH - 1) begin : g_hold
         assign hold = rep_en & vld[SWB_STAGE + 1];
      end else begin : g_nohold
         assign hold = 1'b0;
      end
   endgenerate

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k < SWB_STAGE) begin : g_low
         always_comb begin
            base_v[k] = vld[k + 1];
            base_e[k] = ent[k + 1];
         end
      end else if (k == SWB_STAGE) begin : g_rejoin
         if (k == DEPTH - 1) begin : g_top
            always_comb begin
               base_v[k] = rep_en;
               base_e[k] = head_ent;
            end
         end else begin : g_mid
            always_comb begin
               base_v[k] = rep_en ? 1'b1     : vld[k + 1];
               base_e[k] = rep_en ? head_ent : ent[k + 1];
            end
         end
      end else begin : g_high
         if (k == DEPTH - 1) begin : g_top
            always_comb begin
               base_v[k] = hold ? vld[k] : 1'b0;
               base_e[k] = ent[k];
            end
         end else begin : g_mid
            always_comb begin
               base_v[k] = hold ? vld[k] : vld[k + 1];
               base_e[k] = hold ? ent[k] : ent[k + 1];
            end
         end
      end
   end

   assign ins_ready = (int'(ins_wait) < DEPTH) && !base_v[ins_wait];
   assign accept    = ins_valid & ins_ready;

   always_comb begin
      for (int k = 0; k < DEPTH; k++) begin
         nxt_v[k] = base_v[k];
         nxt_e[k] = base_e[k];
         if (accept && int'(ins_wait) == k) begin
            nxt_v[k] = 1'b1;
            nxt_e[k] = ins_ent;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < DEPTH; k++) begin
         if (!rst_n) begin
            vld[k] <= 1'b0;
            ent[k] <= '0;
         end else begin
            vld[k] <= nxt_v[k];
            ent[k] <= nxt_e[k];
         end
      end
   end

   assign head_valid = vld[0];
   assign head_ent   = ent[0];
   assign st_vld     = vld;
   assign st_ent     = ent;

endmodule

// File: rtl/ciq_readyfile.sv
module ciq_readyfile #(
   parameter int NREG    = 16,
   parameter int REG_W   = 4,
   parameter int MAX_LAT = 4,
   parameter int LAT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_idx,
   input  logic             set_en,
   input  logic [REG_W-1:0] set_idx,
   input  logic [LAT_W-1:0] set_lat,
   output logic [NREG-1:0]  ready
);

   logic [NREG-1:0]  set_bit, clr_bit, imm_mask, due_mask;
   logic [LAT_W-1:0] eff_lat;

   always_comb begin
      if (set_lat == '0)                    eff_lat = LAT_W'(1);
      else if (int'(set_lat) > MAX_LAT)     eff_lat = LAT_W'(MAX_LAT);
      else                                  eff_lat = set_lat;
      set_bit  = set_en ? (NREG'(1) << set_idx) : '0;
      clr_bit  = clr_en ? (NREG'(1) << clr_idx) : '0;
      imm_mask = (eff_lat == LAT_W'(1)) ? set_bit : '0;
   end

   generate
      if (MAX_LAT == 1) begin : g_nodelay
         assign due_mask = '0;
      end else begin : g_delay
         // slot[k] holds registers that turn ready k+1 edges from now
         logic [NREG-1:0] slot [MAX_LAT - 1];
         for (genvar k = 0; k < MAX_LAT - 1; k++) begin : g_slot
            logic [NREG-1:0] ins_here;
            assign ins_here = (eff_lat == LAT_W'(k + 2)) ? set_bit : '0;
            if (k == MAX_LAT - 2) begin : g_last
               always_ff @(posedge clk) begin
                  if (!rst_n) slot[k] <= '0;
                  else        slot[k] <= ins_here;
               end
            end else begin : g_mid
               always_ff @(posedge clk) begin
                  if (!rst_n) slot[k] <= '0;
                  else        slot[k] <= slot[k + 1] | ins_here;
               end
            end
         end
         assign due_mask = slot[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ready <= '1;
      else        ready <= (ready | imm_mask | due_mask) & ~clr_bit;
   end

endmodule

// File: rtl/countdown_issue_queue.sv
module countdown_issue_queue
   import ciq_pkg::*;
#(
   parameter int DEPTH     = CIQ_DEF_DEPTH,
   parameter int SWB_STAGE = 3,
   parameter int NREG      = CIQ_DEF_NREG,
   parameter int MAX_LAT   = CIQ_DEF_MAX_LAT,
   parameter int ID_W      = 4,
   localparam int REG_W    = $clog2(NREG),
   localparam int CNT_W    = $clog2(DEPTH),
   localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [CNT_W-1:0] in_wait,
   input  logic [ID_W-1:0]  in_id,
   input  logic [REG_W-1:0] in_src0,
   input  logic [REG_W-1:0] in_src1,
   input  logic [REG_W-1:0] in_dst,
   input  logic [LAT_W-1:0] in_lat,
   output logic             iss_valid,
   output logic [ID_W-1:0]  iss_id,
   output logic [REG_W-1:0] iss_dst,
   output logic             rep_valid,
   output logic [ID_W-1:0]  rep_id,
   output logic [NREG-1:0]  reg_ready
);

   localparam int ENT_W = int'(ciq_ent_w(ID_W, REG_W, LAT_W));

   if (DEPTH < 2)            begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (SWB_STAGE >= DEPTH)   begin : g_bad_swb   $error("SWB_STAGE must be below DEPTH"); end
   if (NREG < 2)             begin : g_bad_nreg  $error("NREG must be at least 2"); end
   if (MAX_LAT < 1)          begin : g_bad_lat   $error("MAX_LAT must be at least 1"); end

   logic             head_valid;
   logic [ENT_W-1:0] head_ent;
   logic             st_vld [DEPTH];
   logic [ENT_W-1:0] st_ent [DEPTH];
   logic [ID_W-1:0]  h_id;
   logic [REG_W-1:0] h_src0, h_src1, h_dst;
   logic [LAT_W-1:0] head_lat;
   logic             src_ok;

   assign {h_id, h_src0, h_src1, h_dst, head_lat} = head_ent;

   ciq_pipe #(
      .DEPTH(DEPTH), .SWB_STAGE(SWB_STAGE), .ENT_W(ENT_W), .CNT_W(CNT_W)
   ) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_valid (in_valid),
      .ins_wait  (in_wait),
      .ins_ent   ({in_id, in_src0, in_src1, in_dst, in_lat}),
      .ins_ready (in_ready),
      .rep_en    (rep_valid),
      .head_valid(head_valid),
      .head_ent  (head_ent),
      .st_vld    (st_vld),
      .st_ent    (st_ent)
   );

   // Late readiness check at the issue point
   assign src_ok    = reg_ready[h_src0] & reg_ready[h_src1];
   assign iss_valid = head_valid & src_ok;
   assign rep_valid = head_valid & ~src_ok;
   assign iss_id    = h_id;
   assign iss_dst   = h_dst;
   assign rep_id    = h_id;

   ciq_readyfile #(
      .NREG(NREG), .REG_W(REG_W), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)
   ) u_rdy (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_en (in_valid & in_ready),
      .clr_idx(in_dst),
      .set_en (iss_valid),
      .set_idx(h_dst),
      .set_lat(head_lat),
      .ready  (reg_ready)
   );

endmodule

// File: rtl/ciq_checker.sv
module ciq_checker #(
   parameter int DEPTH     = 8,
   parameter int SWB_STAGE = 3,
   parameter int NREG      = 16,
   parameter int ID_W      = 4,
   parameter int REG_W     = 4,
   parameter int CNT_W     = 3,
   parameter int LAT_W     = 3,
   parameter int ENT_W     = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [CNT_W-1:0] in_wait,
   input logic [REG_W-1:0] in_dst,
   input logic             iss_valid,
   input logic [REG_W-1:0] iss_dst,
   input logic [LAT_W-1:0] iss_lat,
   input logic             rep_valid,
   input logic [ID_W-1:0]  rep_id,
   input logic [NREG-1:0]  reg_ready,
   input logic             st_vld [DEPTH],
   input logic [ENT_W-1:0] st_ent [DEPTH]
);

   // R3
   issue_xor_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(iss_valid && rep_valid));

   // R2
   insert_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> st_vld[$past(in_wait)]);

   // R4
   rejoin_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |=> (st_vld[SWB_STAGE] &&
                     st_ent[SWB_STAGE][ENT_W-1 -: ID_W] == $past(rep_id)));

   // R6
   replay_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && int'(in_wait) == SWB_STAGE) |-> !in_ready);

   // R7
   dispatch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !reg_ready[$past(in_dst)]);

   // R8
   fast_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_lat <= LAT_W'(1) &&
       !(in_valid && in_ready && in_dst == iss_dst)) |=> reg_ready[$past(iss_dst)]);

   generate
      if (SWB_STAGE < DEPTH - 1) begin : g_stall
         // R5
         stall_in_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rep_valid && st_vld[SWB_STAGE + 1]) |=>
               (st_vld[SWB_STAGE + 1] &&
                st_ent[SWB_STAGE + 1] == $past(st_ent[SWB_STAGE + 1])));
      end
   endgenerate

endmodule

bind countdown_issue_queue ciq_checker #(
   .DEPTH(DEPTH), .SWB_STAGE(SWB_STAGE), .NREG(NREG), .ID_W(ID_W),
   .REG_W(REG_W), .CNT_W(CNT_W), .LAT_W(LAT_W), .ENT_W(ENT_W)
) u_ciq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_wait  (in_wait),
   .in_dst   (in_dst),
   .iss_valid(iss_valid),
   .iss_dst  (iss_dst),
   .iss_lat  (head_lat),
   .rep_valid(rep_valid),
   .rep_id   (rep_id),
   .reg_ready(reg_ready),
   .st_vld   (st_vld),
   .st_ent   (st_ent)
);

// File: tb/tb_countdown_issue_queue.sv
`timescale 1ns/1ps
module tb_countdown_issue_queue;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [2:0]  in_wait;
   logic [3:0]  in_id, in_src0, in_src1, in_dst;
   logic [2:0]  in_lat;
   logic        iss_valid, rep_valid;
   logic [3:0]  iss_id, iss_dst, rep_id;
   logic [15:0] reg_ready;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   countdown_issue_queue dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_wait(in_wait), .in_id(in_id), .in_src0(in_src0), .in_src1(in_src1),
      .in_dst(in_dst), .in_lat(in_lat), .iss_valid(iss_valid), .iss_id(iss_id),
      .iss_dst(iss_dst), .rep_valid(rep_valid), .rep_id(rep_id),
      .reg_ready(reg_ready)
   );

   // Vector: {wait, id, dst, lat}; sources are registers 0 and 1
   localparam logic [15:0] VEC [6] = '{
      16'h0_1_B_1, 16'h7_2_C_2, 16'h3_3_D_3,
      16'h5_4_E_4, 16'h1_5_F_1, 16'h2_6_2_2
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input int w, input int id, input int s0, input int s1,
                        input int d, input int l);
      in_valid = 1'b1; in_wait = 3'(w); in_id = 4'(id);
      in_src0 = 4'(s0); in_src1 = 4'(s1); in_dst = 4'(d); in_lat = 3'(l);
   endtask

   task automatic idle();
      in_valid = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      idle(); in_wait = '0; in_id = '0; in_src0 = '0; in_src1 = '0; in_dst = '0; in_lat = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(); #1;
      chk("R1", "iss_valid", int'(iss_valid), 0);
      chk("R1", "rep_valid", int'(rep_valid), 0);
      chk("R1", "reg_ready", int'(reg_ready), 16'hFFFF);
      in_wait = 3'd7; #0.1;
      chk("R1", "in_ready", int'(in_ready), 1);

      // R2 and R8: vector walk, one instruction at a time
      for (int v = 0; v < 6; v++) begin
         int w, id, d, l, k;
         w = int'(VEC[v][15:12]); id = int'(VEC[v][11:8]);
         d = int'(VEC[v][7:4]);   l  = int'(VEC[v][3:0]);
         @(negedge clk);
         drive(w, id, 0, 1, d, l); #1;
         chk("R2", "in_ready", int'(in_ready), 1);
         k = 0;
         for (int c = 1; c <= 12; c++) begin
            step(); #1;
            if (c == 1) chk("R7", "dst cleared", int'(reg_ready[d]), (w == 0) ? 0 : 0);
            if (iss_valid && k == 0) begin
               k = c;
               chk("R2", "iss_id", int'(iss_id), id);
               chk("R2", "iss_dst", int'(iss_dst), d);
               break;
            end
         end
         chk("R2", "issue cycle", k, w + 1);
         for (int j = 1; j < l; j++) begin
            step(); #1;
            chk("R8", "ready early", int'(reg_ready[d]), 0);
         end
         step(); #1;
         chk("R8", "ready on time", int'(reg_ready[d]), 1);
      end
      repeat (2) step();

      // R3 R4 R5 R6 R7 R8: replay colliding with a parked entry and an insertion
      @(negedge clk); drive(6, 6, 0, 1, 8, 1); #1;          // Y, c0
      chk("R6", "Y accepted", int'(in_ready), 1);
      @(negedge clk); drive(0, 3, 0, 1, 7, 4); #1;          // P, c0+1
      chk("R6", "P accepted", int'(in_ready), 1);
      @(negedge clk); drive(0, 4, 7, 0, 10, 1); #1;         // X, c0+2
      chk("R6", "X accepted", int'(in_ready), 1);
      chk("R2", "P issues", int'(iss_valid && iss_id == 4'd3), 1);
      chk("R7", "ready[7] cleared", int'(reg_ready[7]), 0);
      @(negedge clk); drive(3, 7, 0, 1, 9, 1); #1;          // Z refused, c0+3
      chk("R6", "Z refused", int'(in_ready), 0);
      chk("R3", "X replayed", int'(rep_valid), 1);
      chk("R3", "rep_id", int'(rep_id), 4);
      chk("R3", "X not issued", int'(iss_valid), 0);
      step(); #1;                                            // c0+4
      chk("R6", "ready[9] untouched", int'(reg_ready[9]), 1);
      chk("R5", "quiet c0+4", int'(iss_valid | rep_valid), 0);
      step(); #1;                                            // c0+5
      chk("R8", "ready[7] early", int'(reg_ready[7]), 0);
      step(); #1;                                            // c0+6
      chk("R8", "ready[7] on time", int'(reg_ready[7]), 1);
      chk("R5", "quiet c0+6", int'(iss_valid | rep_valid), 0);
      step(); #1;                                            // c0+7
      chk("R4", "X reissue", int'(iss_valid && iss_id == 4'd4), 1);
      step(); #1;                                            // c0+8
      chk("R5", "Y delayed issue", int'(iss_valid && iss_id == 4'd6), 1);
      step(); #1;                                            // c0+9
      chk("R6", "Z never issues", int'(iss_valid | rep_valid), 0);
      repeat (3) step();

      // R6: insertion refused when a shifting entry takes the target stage
      @(negedge clk); drive(2, 8, 0, 1, 3, 1); #1;          // A, c
      chk("R6", "A accepted", int'(in_ready), 1);
      @(negedge clk); drive(1, 9, 0, 1, 4, 1); #1;          // B, c+1
      chk("R6", "B collides", int'(in_ready), 0);
      @(negedge clk); #1;                                    // c+2
      chk("R6", "ready[4] untouched", int'(reg_ready[4]), 1);
      drive(1, 9, 0, 1, 4, 1); #0.1;
      chk("R6", "B retry accepted", int'(in_ready), 1);
      step(); #1;                                            // c+3
      chk("R2", "A issues", int'(iss_valid && iss_id == 4'd8), 1);
      step(); #1;                                            // c+4
      chk("R2", "B issues", int'(iss_valid && iss_id == 4'd9), 1);
      repeat (3) step();

      // R8: latency 1 allows back-to-back dependent issue
      @(negedge clk); drive(0, 10, 0, 1, 6, 1); #1;
      @(negedge clk); drive(0, 11, 6, 1, 5, 1); #1;
      chk("R8", "producer issues", int'(iss_valid && iss_id == 4'd10), 1);
      step(); #1;
      chk("R8", "dependent issues", int'(iss_valid && iss_id == 4'd11), 1);
      chk("R3", "no replay", int'(rep_valid), 0);
      repeat (3) step();

      finish_run();
   end

endmodule